// File: doc/BRIEF.md
# RS-485 Automatic Direction Controller

This block sits inside one UART channel and drives the active-low direction pin of a half-duplex RS-485 transceiver. The pin is low while the channel drives the shared line and high while it listens. The block follows the transmitter's own status lines: a pulse at the start of each character, a busy flag from the shift register, and the empty flag of the transmit queue. It keeps the driver enabled from the first start bit until the last stop bit of the final queued character has left the shift register. A programmable number of guard cycles follows before the pin is released.

The function is switched on only when two separate configuration bits from the channel's register set are both 1. Otherwise, and always after reset, the pin carries the plain register-controlled modem-control value. The output comes from a flop, so changes on the status inputs cannot glitch it. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While reset is asserted the output `dir_n` is 1. After reset the automatic function is off, so `dir_n` equals the `modem_rts_n` value sampled at the previous clock edge.
- R2: The automatic function is on only when `cfg_efr_auto` and `cfg_fctr_auto` are both 1. With either bit at 0, `dir_n` follows `modem_rts_n` one clock later, whatever the transmitter does.
- R3: With the function on and no transmitter activity for more than `HOLD_CYCLES` cycles, `dir_n` is 1 (receive). Activity means `tx_start`=1, `tx_busy`=1 or `txq_empty`=0.
- R4: With the function on, one clock edge after a cycle with `tx_start`=1, `dir_n` is 0.
- R5: With the function on, `dir_n` is 0 one edge after every cycle with `tx_busy`=1 or `txq_empty`=0. Back-to-back characters therefore keep the driver enabled without a gap.
- R6: After the last active cycle, `dir_n` stays 0 for exactly `HOLD_CYCLES` further cycles and returns to 1 on the next edge.
- R7: When either enable bit drops, even in the middle of a character, `dir_n` takes the `modem_rts_n` value at the next clock edge.
- R8: Activity during the guard window cancels the release: `dir_n` stays 0, and the guard count starts over after the new activity ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_efr_auto | input | 1 | First enable bit for automatic direction |
| cfg_fctr_auto | input | 1 | Second enable bit for automatic direction |
| modem_rts_n | input | 1 | Register-controlled modem-control pin value, used when the function is off |
| txq_empty | input | 1 | Transmit holding register/queue empty |
| tx_busy | input | 1 | Shift register is sending (start through last stop bit) |
| tx_start | input | 1 | One-cycle pulse when a character begins |
| dir_n | output | 1 | Direction pin to the transceiver: 0 drive, 1 receive |

## Verification
The bench builds the block with `HOLD_CYCLES` = 3 rather than the default of 2. This makes the guard window long enough to retrigger it in its middle cycle and to check the release on the exact fourth quiet edge. Random bursts of start pulses, busy stretches and queue occupancy run with the enables toggling now and then. This reaches disable during a character, enable while the queue is already non-empty, and gaps of every length around the guard window.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_GUARD = 2'd2
  } dir_state_e;

endpackage

// File: rtl/rs485_rst_sync.sv
module rs485_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rs485_en_qual.sv
module rs485_en_qual #(
  parameter int EN_BITS = 2
) (
  input  logic [EN_BITS-1:0] en_bits,
  output logic               auto_en
);

  logic [EN_BITS:0] chain;

  assign chain[0] = 1'b1;

  for (genvar g = 0; g < EN_BITS; g++) begin : g_and
    assign chain[g+1] = chain[g] & en_bits[g];
  end

  assign auto_en = chain[EN_BITS];

endmodule

// File: rtl/rs485_act_fsm.sv
module rs485_act_fsm
  import rs485_dir_pkg::*;
#(
  parameter int HOLD_CYCLES = 2,
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       activity,
  output logic       drive_d,
  output dir_state_e state_q
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((HOLD_CYCLES > 0) ? HOLD_CYCLES - 1 : 0);

  dir_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (!auto_en) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (activity) state_d = ST_SEND;
        end
        ST_SEND: begin
          if (!activity) begin
            if (HOLD_CYCLES == 0) begin
              state_d = ST_IDLE;
            end else begin
              state_d = ST_GUARD;
              cnt_d   = '0;
              cnt_en  = 1'b1;
            end
          end
        end
        ST_GUARD: begin
          if (activity) begin
            state_d = ST_SEND;
          end else if (cnt_q == CNT_LAST) begin
            state_d = ST_IDLE;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign drive_d = (state_d != ST_IDLE);

  if (HOLD_CYCLES > 0) begin : g_guard_chk
    AST_GUARD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GUARD) |-> (cnt_q <= CNT_LAST)) else $error("guard count overran"); // R6
  end

  AST_ACT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && activity) |=> (state_q == ST_SEND)) else $error("activity did not enter send"); // R5

endmodule

// File: rtl/rs485_pin_reg.sv
module rs485_pin_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic drive_d,
  input  logic modem_rts_n,
  output logic dir_n
);

  logic pin_d, pin_q, pin_en;

  always_comb begin
    pin_d  = auto_en ? ~drive_d : modem_rts_n;
    pin_en = (pin_d != pin_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
    end else if (pin_en) begin
      pin_q <= pin_d;
    end
  end

  assign dir_n = pin_q;

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int HOLD_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_efr_auto,
  input  logic cfg_fctr_auto,
  input  logic modem_rts_n,
  input  logic txq_empty,
  input  logic tx_busy,
  input  logic tx_start,
  output logic dir_n
);

  logic       rst_n_s;
  logic       auto_en;
  logic       activity;
  logic       drive_d;
  dir_state_e state_q;

  rs485_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rs485_en_qual #(.EN_BITS(2)) i_en_qual (
    .en_bits ({cfg_fctr_auto, cfg_efr_auto}),
    .auto_en (auto_en)
  );

  assign activity = tx_start | tx_busy | ~txq_empty;

  rs485_act_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) i_act_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .auto_en  (auto_en),
    .activity (activity),
    .drive_d  (drive_d),
    .state_q  (state_q)
  );

  rs485_pin_reg i_pin_reg (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .auto_en     (auto_en),
    .drive_d     (drive_d),
    .modem_rts_n (modem_rts_n),
    .dir_n       (dir_n)
  );

  AST_DISABLED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(cfg_efr_auto && cfg_fctr_auto) |=> (dir_n == $past(modem_rts_n))) else $error("pin not from modem value"); // R7

  AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_efr_auto && cfg_fctr_auto && tx_start) |=> !dir_n) else $error("start did not drive"); // R4

  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_efr_auto && cfg_fctr_auto && (tx_busy || !txq_empty)) |=> !dir_n) else $error("released while busy"); // R5

  AST_IDLE_RECEIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((state_q == ST_IDLE) && $past(auto_en)) |-> dir_n) else $error("idle but driving"); // R3

endmodule

// File: tb/test_rs485_dir_ctrl.sv
module test_rs485_dir_ctrl;

  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_efr_auto, cfg_fctr_auto, modem_rts_n;
  logic txq_empty, tx_busy, tx_start;
  logic dir_n;

  int checks = 0;
  int errors = 0;
  int quiet  = HOLD + 1;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rs485_dir_ctrl #(.HOLD_CYCLES(HOLD)) i_rs485_dir_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_efr_auto  (cfg_efr_auto),
    .cfg_fctr_auto (cfg_fctr_auto),
    .modem_rts_n   (modem_rts_n),
    .txq_empty     (txq_empty),
    .tx_busy       (tx_busy),
    .tx_start      (tx_start),
    .dir_n         (dir_n)
  );

  function automatic int next_quiet(int q, bit en, bit act);
    if (!en) return HOLD + 1;
    if (act) return 0;
    if (q <= HOLD) return q + 1;
    return q;
  endfunction

  function automatic bit expect_pin(int q, bit en, bit modem);
    if (!en) return modem;
    return (q <= HOLD) ? 1'b0 : 1'b1;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dir_n=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag, bit e1, bit e2, bit m, bit emp, bit bsy, bit st);
    bit en, act, exp;
    cfg_efr_auto = e1; cfg_fctr_auto = e2; modem_rts_n = m;
    txq_empty = emp; tx_busy = bsy; tx_start = st;
    en    = e1 & e2;
    act   = st | bsy | ~emp;
    quiet = next_quiet(quiet, en, act);
    exp   = expect_pin(quiet, en, m);
    @(negedge clk);
    check(tag, dir_n, exp);
  endtask

  initial begin
    for (int n = 0; n < 200000; n++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: dir_n=%0b expected end of run", dir_n);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    bit e1, e2, m, emp, bsy, st;
    seed = 32'h4852;
    void'($urandom(seed));
    rst_n = 1'b0;
    cfg_efr_auto = 1'b1; cfg_fctr_auto = 1'b1; modem_rts_n = 1'b0;
    txq_empty = 1'b0; tx_busy = 1'b1; tx_start = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset high", dir_n, 1'b1);
    cfg_efr_auto = 1'b0; cfg_fctr_auto = 1'b0; modem_rts_n = 1'b1;
    txq_empty = 1'b1; tx_busy = 1'b0; tx_start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", dir_n, 1'b1);
    cyc("R1 follows modem", 0, 0, 0, 1, 0, 0);
    cyc("R1 follows modem", 0, 0, 1, 1, 0, 0);

    cyc("R2 efr only", 1, 0, 1, 0, 1, 1);
    cyc("R2 efr only", 1, 0, 0, 0, 1, 0);
    cyc("R2 fctr only", 0, 1, 1, 0, 1, 1);
    cyc("R2 fctr only", 0, 1, 0, 1, 1, 0);

    cyc("R3 idle receive", 1, 1, 0, 1, 0, 0);
    cyc("R3 idle receive", 1, 1, 0, 1, 0, 0);

    cyc("R4 start drives", 1, 1, 1, 1, 0, 1);
    cyc("R5 busy", 1, 1, 1, 0, 1, 0);
    cyc("R5 back to back", 1, 1, 1, 0, 1, 1);
    cyc("R5 queue holds", 1, 1, 1, 0, 1, 0);
    cyc("R5 last char", 1, 1, 1, 1, 1, 0);
    for (int k = 0; k < HOLD; k++) cyc("R6 guard", 1, 1, 1, 1, 0, 0);
    cyc("R6 release", 1, 1, 1, 1, 0, 0);
    check("R6 released high", dir_n, 1'b1);

    cyc("R4 start", 1, 1, 1, 1, 1, 1);
    cyc("R8 quiet1", 1, 1, 1, 1, 0, 0);
    cyc("R8 quiet2", 1, 1, 1, 1, 0, 0);
    cyc("R8 retrigger", 1, 1, 1, 1, 0, 1);
    for (int k = 0; k < HOLD; k++) cyc("R8 guard restart", 1, 1, 1, 1, 0, 0);
    cyc("R8 release", 1, 1, 1, 1, 0, 0);

    cyc("R4 start", 1, 1, 1, 0, 1, 1);
    cyc("R7 disable mid char", 0, 1, 1, 0, 1, 0);
    cyc("R7 modem low", 1, 0, 0, 0, 1, 0);
    cyc("R5 reenable busy", 1, 1, 1, 0, 1, 0);

    for (int n = 0; n < 3000; n++) begin
      e1  = ($urandom % 16) != 0;
      e2  = ($urandom % 16) != 0;
      m   = $urandom % 2;
      bsy = ($urandom % 3) == 0;
      emp = ($urandom % 4) != 0;
      st  = ($urandom % 8) == 0;
      if (!(e1 & e2)) cyc("R7 random disabled", e1, e2, m, emp, bsy, st);
      else if (st) cyc("R4 random start", e1, e2, m, emp, bsy, st);
      else if (bsy | ~emp) cyc("R5 random active", e1, e2, m, emp, bsy, st);
      else cyc("R6 random quiet", e1, e2, m, emp, bsy, st);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule